// File: doc/BRIEF.md
# Write Guard and Protection Unit

This block keeps the status byte of a small serial EEPROM. It decides whether each write request that the command decoder passes to it may go ahead. The decoder sends it one-cycle pulses: a write-enable command, a write-disable command, a status write carrying a data byte, and an array commit carrying a start address and a byte count. It also sends a pulse when chip select goes inactive, which closes the transaction. The hardware write-protect pin comes straight in, active low.

A status or array write is judged only when the transaction closes. At that point the unit returns a one-cycle grant or reject. A grant starts a self-timed write cycle of a set number of system clocks, and the busy bit is set for that whole time. The two protect bits live in plain registers and are cleared by reset, which stands in for power-up.

Top module: `write_guard`

## Requirements
- R1: After reset, statusByte reads 8'hF0 and grant and reject are both 0. Bits 7:4 always read 1111. Bit 3 and bit 2 are the protect code (bit 3 high), bit 1 is the write-enable flag, and bit 0 is busy (1 = write cycle running).
- R2: A write-enable command sets bit 1 only on the csRise pulse that closes its transaction. Before that pulse, bit 1 keeps its old value.
- R3: A write-disable command clears bit 1 in the cycle after its pulse, with no need to wait for csRise.
- R4: A granted status write loads wrsrData[3:2] into bits 3:2 and clears bit 1. All other data bits are ignored. The grant pulse appears in the cycle after csRise.
- R5: A status or array write that closes while bit 1 is 0 is rejected.
- R6: The protect code selects the protected region. 00 protects nothing. 01 protects addresses at or above three quarters of the depth (0x180 for 512 bytes). 10 protects the upper half (0x100 and up). 11 protects the whole array. An array commit is rejected if any byte it touches is protected. The touched bytes start at the start address and wrap within the aligned PAGE_BYTES page.
- R7: A status or array write is rejected if wpN is low in the csRise cycle, or in any cycle between the command pulse and csRise.
- R8: After a grant, bit 0 is 1 for exactly CYCLE_CLKS clocks. The first of these is the cycle in which grant is high.
- R9: While bit 0 is 1, every command pulse and csRise is ignored: no grant, no reject, no change of bit 1. This includes a command arriving in the last busy cycle. wpN has no effect on a cycle that is already running.
- R10: A rejected write leaves bits 3:1 unchanged and does not set bit 0.
- R11: An array commit with a byte count of 0 is rejected.
- R12: grant and reject are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset (power-up) |
| evWren | input | 1 | Write-enable command pulse |
| evWrdi | input | 1 | Write-disable command pulse |
| evWrsr | input | 1 | Status write command pulse |
| wrsrData | input | 8 | Data byte of the status write |
| evArray | input | 1 | Array commit pulse |
| arrayAddr | input | ADDR_W | Start byte address of the commit |
| arrayCount | input | CNT_W | Number of bytes loaded (0..PAGE_BYTES) |
| csRise | input | 1 | Transaction close (chip select deasserted) |
| wpN | input | 1 | Write-protect pin, active low |
| grant | output | 1 | Write accepted, one cycle |
| reject | output | 1 | Write refused, one cycle |
| statusByte | output | 8 | Status byte |

## Verification
Two events can land in the same cycle here. The first is the last cycle of a running write cycle meeting the arrival of a new command. The second is the protect pin going low in the very cycle the transaction closes. The bench measures the busy run clock by clock and places a write-enable pulse on its final busy cycle. It then checks that the flag stays clear once busy drops. It also drives wpN low exactly with csRise and expects a reject, with the status byte unchanged.

// File: rtl/write_guard_pkg.sv
`timescale 1ns/1ps
package write_guard_pkg;

  typedef enum logic [1:0] {
    ARM_NONE  = 2'd0,
    ARM_WREN  = 2'd1,
    ARM_WRSR  = 2'd2,
    ARM_ARRAY = 2'd3
  } armKind_e;

  typedef struct packed {
    logic setWel;
    logic clrWel;
    logic latchReq;
    logic loadProt;
    logic startCycle;
  } guardStrobe_t;

  localparam logic [3:0] STATUS_FILL = 4'b1111;

endpackage

// File: rtl/write_guard_range.sv
`timescale 1ns/1ps
module write_guard_range #(
  parameter int ADDR_W     = 9,
  parameter int PAGE_BYTES = 16,
  parameter int CNT_W      = $clog2(PAGE_BYTES) + 1
) (
  input  logic [1:0]        protCode,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [CNT_W-1:0]  byteCount,
  output logic              hit,
  output logic              emptyReq
);
  localparam int OFF_W = $clog2(PAGE_BYTES);
  localparam int SUM_W = ((OFF_W > CNT_W) ? OFF_W : CNT_W) + 1;
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] HALF_BASE    = ADDR_W'(DEPTH / 2);
  localparam logic [ADDR_W-1:0] QUARTER_BASE = ADDR_W'(DEPTH - DEPTH / 4);

  logic [SUM_W-1:0]  endOff;
  logic [ADDR_W-1:0] maxAddr;
  logic [3:0]        codeHit;

  // Protected regions are all upper-contiguous, so the highest touched
  // address decides. A run that wraps inside the page reaches the page end.
  always_comb begin
    endOff = SUM_W'(startAddr[OFF_W-1:0]) + SUM_W'(byteCount) - SUM_W'(1);
    if (endOff >= SUM_W'(PAGE_BYTES))
      maxAddr = {startAddr[ADDR_W-1:OFF_W], {OFF_W{1'b1}}};
    else
      maxAddr = {startAddr[ADDR_W-1:OFF_W], endOff[OFF_W-1:0]};
  end

  for (genvar g = 0; g < 4; g++) begin : g_code
    if (g == 0) begin : g_none
      assign codeHit[g] = 1'b0;
    end else if (g == 1) begin : g_quarter
      assign codeHit[g] = (maxAddr >= QUARTER_BASE);
    end else if (g == 2) begin : g_half
      assign codeHit[g] = (maxAddr >= HALF_BASE);
    end else begin : g_full
      assign codeHit[g] = 1'b1;
    end
  end

  assign hit      = codeHit[protCode];
  assign emptyReq = (byteCount == '0);
endmodule

// File: rtl/write_guard_datapath.sv
`timescale 1ns/1ps
module write_guard_datapath
  import write_guard_pkg::*;
#(
  parameter int ADDR_W     = 9,
  parameter int PAGE_BYTES = 16,
  parameter int CNT_W      = $clog2(PAGE_BYTES) + 1,
  parameter int CYCLE_CLKS = 1000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  guardStrobe_t      strobe,
  input  logic [1:0]        newProt,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [CNT_W-1:0]  reqCount,
  output logic              wel,
  output logic [1:0]        prot,
  output logic              busy,
  output logic              hit,
  output logic              emptyReq
);
  localparam int TMR_W = $clog2(CYCLE_CLKS + 1);

  logic [TMR_W-1:0]  cycleLeft;
  logic [1:0]        heldProt;
  logic [ADDR_W-1:0] heldAddr;
  logic [CNT_W-1:0]  heldCount;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      heldProt  <= '0;
      heldAddr  <= '0;
      heldCount <= '0;
    end else if (strobe.latchReq) begin
      heldProt  <= newProt;
      heldAddr  <= reqAddr;
      heldCount <= reqCount;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel <= 1'b0;
    end else if (strobe.clrWel) begin
      wel <= 1'b0;
    end else if (strobe.setWel) begin
      wel <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prot <= '0;
    end else if (strobe.loadProt) begin
      prot <= heldProt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      cycleLeft <= '0;
    end else if (strobe.startCycle) begin
      busy      <= 1'b1;
      cycleLeft <= TMR_W'(CYCLE_CLKS - 1);
    end else if (busy) begin
      if (cycleLeft == '0) busy <= 1'b0;
      else                 cycleLeft <= cycleLeft - 1'b1;
    end
  end

  write_guard_range #(
    .ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES), .CNT_W(CNT_W)
  ) u_range (
    .protCode (prot),
    .startAddr(heldAddr),
    .byteCount(heldCount),
    .hit      (hit),
    .emptyReq (emptyReq)
  );
endmodule

// File: rtl/write_guard_ctrl.sv
`timescale 1ns/1ps
module write_guard_ctrl
  import write_guard_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         evWren,
  input  logic         evWrdi,
  input  logic         evWrsr,
  input  logic         evArray,
  input  logic         csRise,
  input  logic         wpN,
  input  logic         busy,
  input  logic         wel,
  input  logic         hit,
  input  logic         emptyReq,
  output guardStrobe_t strobe,
  output logic         grant,
  output logic         reject
);
  armKind_e armQ, armNext;
  logic     wpLostQ, wpLostNext;
  logic     idle, armIsWrite, writeOk, closeWrite;

  assign idle       = !busy;
  assign armIsWrite = (armQ == ARM_WRSR) || (armQ == ARM_ARRAY);
  assign closeWrite = idle && csRise && armIsWrite;

  always_comb begin
    writeOk = wel && wpN && !wpLostQ;
    if (armQ == ARM_ARRAY) writeOk = writeOk && !hit && !emptyReq;
  end

  always_comb begin
    strobe = '0;
    if (idle) begin
      if (csRise && armQ == ARM_WREN) strobe.setWel = 1'b1;
      if (closeWrite && writeOk) begin
        strobe.clrWel     = 1'b1;
        strobe.startCycle = 1'b1;
        strobe.loadProt   = (armQ == ARM_WRSR);
      end
      if (evWrdi) strobe.clrWel = 1'b1;
      if (evWrsr || evArray) strobe.latchReq = 1'b1;
    end
  end

  always_comb begin
    armNext    = armQ;
    wpLostNext = wpLostQ;
    if (idle) begin
      if (csRise) begin
        armNext    = ARM_NONE;
        wpLostNext = 1'b0;
      end else if (evWren || evWrdi || evWrsr || evArray) begin
        wpLostNext = 1'b0;
        if (evWren)      armNext = ARM_WREN;
        else if (evWrsr) armNext = ARM_WRSR;
        else if (evArray) armNext = ARM_ARRAY;
        else             armNext = ARM_NONE;
      end else if (armIsWrite && !wpN) begin
        wpLostNext = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armQ    <= ARM_NONE;
      wpLostQ <= 1'b0;
      grant   <= 1'b0;
      reject  <= 1'b0;
    end else begin
      armQ    <= armNext;
      wpLostQ <= wpLostNext;
      grant   <= closeWrite && writeOk;
      reject  <= closeWrite && !writeOk;
    end
  end
endmodule

// File: rtl/write_guard.sv
`timescale 1ns/1ps
module write_guard
  import write_guard_pkg::*;
#(
  parameter int ADDR_W     = 9,
  parameter int PAGE_BYTES = 16,
  parameter int CNT_W      = $clog2(PAGE_BYTES) + 1,
  parameter int CYCLE_CLKS = 1000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evWren,
  input  logic              evWrdi,
  input  logic              evWrsr,
  input  logic [7:0]        wrsrData,
  input  logic              evArray,
  input  logic [ADDR_W-1:0] arrayAddr,
  input  logic [CNT_W-1:0]  arrayCount,
  input  logic              csRise,
  input  logic              wpN,
  output logic              grant,
  output logic              reject,
  output logic [7:0]        statusByte
);
  guardStrobe_t strobe;
  logic       wel, busy, hit, emptyReq;
  logic [1:0] prot;
  logic       unusedWrsrBits;

  assign unusedWrsrBits = ^{wrsrData[7:4], wrsrData[1:0]};

  write_guard_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .evWren(evWren), .evWrdi(evWrdi), .evWrsr(evWrsr), .evArray(evArray),
    .csRise(csRise), .wpN(wpN),
    .busy(busy), .wel(wel), .hit(hit), .emptyReq(emptyReq),
    .strobe(strobe), .grant(grant), .reject(reject)
  );

  write_guard_datapath #(
    .ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES), .CNT_W(CNT_W), .CYCLE_CLKS(CYCLE_CLKS)
  ) u_data (
    .clk(clk), .rst_n(rst_n), .strobe(strobe),
    .newProt(wrsrData[3:2]), .reqAddr(arrayAddr), .reqCount(arrayCount),
    .wel(wel), .prot(prot), .busy(busy), .hit(hit), .emptyReq(emptyReq)
  );

  assign statusByte = {STATUS_FILL, prot, wel, busy};
endmodule

// File: rtl/write_guard_checker.sv
`timescale 1ns/1ps
module write_guard_checker #(
  parameter int CYCLE_CLKS = 1000000
) (
  input logic       clk,
  input logic       rst_n,
  input logic       csRise,
  input logic       evWrdi,
  input logic       grant,
  input logic       reject,
  input logic [7:0] statusByte
);
  int runLen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             runLen <= 0;
    else if (statusByte[0]) runLen <= runLen + 1;
    else                    runLen <= 0;
  end

  assert_fill_ones_R1: assert property (@(posedge clk) disable iff (!rst_n)
    statusByte[7:4] == 4'b1111);

  assert_wel_rise_on_close_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(statusByte[1]) |-> $past(csRise));

  assert_wrdi_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(evWrdi && !statusByte[0]) |-> !statusByte[1]);

  assert_grant_clears_wel_R4: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> !statusByte[1]);

  assert_prot_only_on_grant_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !grant |-> $stable(statusByte[3:2]));

  assert_grant_starts_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> statusByte[0]);

  assert_busy_length_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(statusByte[0]) |-> runLen == CYCLE_CLKS);

  assert_no_grant_while_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (grant || reject) |-> !$past(statusByte[0]));

  assert_reject_keeps_state_R10: assert property (@(posedge clk) disable iff (!rst_n)
    reject |-> (!statusByte[0] && statusByte[1] == $past(statusByte[1])));

  assert_grant_reject_excl_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(grant && reject));
endmodule

bind write_guard write_guard_checker #(.CYCLE_CLKS(CYCLE_CLKS)) u_guardChk (
  .clk(clk), .rst_n(rst_n), .csRise(csRise), .evWrdi(evWrdi),
  .grant(grant), .reject(reject), .statusByte(statusByte)
);

// File: tb/write_guard_bench.sv
`timescale 1ns/1ps
module write_guard_bench;
  localparam int ADDR_W = 9;
  localparam int PAGE   = 16;
  localparam int CNT_W  = 5;
  localparam int CYC    = 24;

  logic clk = 1'b0;
  logic rst_n;
  logic evWren, evWrdi, evWrsr, evArray, csRise, wpN;
  logic [7:0] wrsrData;
  logic [ADDR_W-1:0] arrayAddr;
  logic [CNT_W-1:0] arrayCount;
  logic grant, reject;
  logic [7:0] statusByte;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 0;
  bit mWel = 0;
  logic [1:0] mProt = 2'b00;

  always #2.5 clk = ~clk;

  write_guard #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE), .CNT_W(CNT_W), .CYCLE_CLKS(CYC)) u_write_guard (
    .clk(clk), .rst_n(rst_n), .evWren(evWren), .evWrdi(evWrdi), .evWrsr(evWrsr),
    .wrsrData(wrsrData), .evArray(evArray), .arrayAddr(arrayAddr), .arrayCount(arrayCount),
    .csRise(csRise), .wpN(wpN), .grant(grant), .reject(reject), .statusByte(statusByte)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected<150000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit addrProtected(input logic [1:0] p, input logic [8:0] a);
    case (p)
      2'b00:   return 1'b0;
      2'b01:   return a >= 9'd384;
      2'b10:   return a >= 9'd256;
      default: return 1'b1;
    endcase
  endfunction

  function automatic bit pageHit(input logic [1:0] p, input logic [8:0] a, input int n);
    bit h = 0;
    for (int i = 0; i < n; i++) begin
      logic [3:0] off = a[3:0] + 4'(i);
      if (addrProtected(p, {a[8:4], off})) h = 1;
    end
    return h;
  endfunction

  // poke 1: commands and a WP dip during busy; poke 2: command in last busy cycle
  task automatic waitBusy(input int poke);
    int n = 1;
    int pulses = 0;
    while (1) begin
      if (poke == 1) begin
        if (n == 2) evWren = 1;
        if (n == 3) begin evWren = 0; csRise = 1; wpN = 0; end
        if (n == 4) begin csRise = 0; evArray = 1; arrayAddr = 9'h000; arrayCount = 5'd1; end
        if (n == 5) begin evArray = 0; csRise = 1; end
        if (n == 6) begin csRise = 0; wpN = 1; end
      end
      if (poke == 2 && n == CYC) evWren = 1;
      @(negedge clk);
      if (grant || reject) pulses++;
      if (!statusByte[0]) break;
      n++;
      if (n > CYC + 8) break;
    end
    check(n == CYC, "R8 busy length", 16'(n), 16'(CYC));
    check(pulses == 0, "R9 no pulse while busy", 16'(pulses), 16'd0);
    if (poke == 1) check(statusByte[1] == 1'b0, "R9 WREN ignored while busy", 16'(statusByte[1]), 16'd0);
    if (poke == 2) begin
      evWren = 0; csRise = 1;
      @(negedge clk);
      csRise = 0;
      @(negedge clk);
      check(statusByte[1] == 1'b0, "R9 WREN in last busy cycle ignored", 16'(statusByte[1]), 16'd0);
    end
  endtask

  // kind: 0 enable, 1 disable, 2 status write, 3 array commit
  // wpMode: 0 high, 1 dip between command and close, 2 low at close
  task automatic runTxn(input int kind, input logic [7:0] data, input logic [8:0] addr,
                        input int cnt, input int wpMode, input int poke);
    bit ok, expG, expR, welBefore;
    string tag;
    welBefore = mWel;
    @(negedge clk);
    case (kind)
      0: evWren = 1;
      1: evWrdi = 1;
      2: begin evWrsr = 1; wrsrData = data; end
      default: begin evArray = 1; arrayAddr = addr; arrayCount = 5'(cnt); end
    endcase
    @(negedge clk);
    evWren = 0; evWrdi = 0; evWrsr = 0; evArray = 0;
    if (kind == 1) check(statusByte[1] == 1'b0, "R3 disable before close", 16'(statusByte[1]), 16'd0);
    if (wpMode == 1 && kind >= 2) wpN = 0;
    @(negedge clk);
    if (kind == 0 && !mWel) check(statusByte[1] == 1'b0, "R2 no enable before close", 16'(statusByte[1]), 16'd0);
    wpN = (wpMode == 2) ? 1'b0 : 1'b1;
    csRise = 1;
    @(negedge clk);
    csRise = 0; wpN = 1;
    ok = 0;
    if (kind == 0) mWel = 1;
    if (kind == 1) mWel = 0;
    if (kind == 2) ok = mWel && (wpMode == 0);
    if (kind == 3) ok = mWel && (wpMode == 0) && (cnt != 0) && !pageHit(mProt, addr, cnt);
    expG = (kind >= 2) && ok;
    expR = (kind >= 2) && !ok;
    if (kind == 2) tag = "R4";
    else if (kind < 2) tag = "R2";
    else if (wpMode != 0) tag = "R7";
    else if (!welBefore) tag = "R5";
    else if (cnt == 0) tag = "R11";
    else tag = "R6";
    if (expG) begin
      if (kind == 2) mProt = data[3:2];
      mWel = 0;
    end
    check(grant == expG && reject == expR, {tag, " grant/reject"}, {14'd0, grant, reject}, {14'd0, expG, expR});
    check(statusByte == {4'hF, mProt, mWel, expG}, expR ? "R10 status after reject" : {tag, " status"},
          16'(statusByte), 16'({4'hF, mProt, mWel, expG}));
    if (expG) waitBusy(poke);
  endtask

  initial begin
    int seedDummy;
    seedDummy = $urandom(32'd20240611);
    rst_n = 0; evWren = 0; evWrdi = 0; evWrsr = 0; evArray = 0; csRise = 0; wpN = 1;
    wrsrData = 0; arrayAddr = 0; arrayCount = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(statusByte == 8'hF0, "R1 reset status", 16'(statusByte), 16'h00F0);
    check(!grant && !reject, "R1 reset pulses", {14'd0, grant, reject}, 16'd0);

    runTxn(3, 8'h00, 9'h010, 1, 0, 0);      // R5 reject without enable
    runTxn(2, 8'h04, 9'h000, 0, 0, 0);      // R5 status write without enable
    runTxn(0, 8'h00, 9'h000, 0, 0, 0);      // R2
    runTxn(2, 8'h06, 9'h000, 0, 0, 0);      // R4 prot=01, bits 1 and 0 of data ignored
    runTxn(0, 8'h00, 9'h000, 0, 0, 0);
    runTxn(3, 8'h00, 9'h17F, 1, 0, 0);      // R6 just below quarter region
    runTxn(0, 8'h00, 9'h000, 0, 0, 0);
    runTxn(3, 8'h00, 9'h185, 1, 0, 0);      // R6 reject, R10 enable kept
    runTxn(3, 8'h00, 9'h17C, 8, 0, 0);      // R6 wrap stays in page, grant
    runTxn(0, 8'h00, 9'h000, 0, 0, 0);
    runTxn(3, 8'h00, 9'h100, 0, 0, 0);      // R11 zero count
    runTxn(3, 8'h00, 9'h020, 4, 1, 0);      // R7 dip
    runTxn(3, 8'h00, 9'h020, 4, 2, 0);      // R7 low at close (same cycle)
    runTxn(2, 8'h08, 9'h000, 0, 0, 1);      // R4 prot=10, R9 pokes while busy
    runTxn(0, 8'h00, 9'h000, 0, 0, 0);
    runTxn(3, 8'h00, 9'h100, 1, 0, 0);      // R6 half region reject
    runTxn(3, 8'h00, 9'h0FF, 1, 0, 2);      // grant, R9 collision in last busy cycle
    runTxn(0, 8'h00, 9'h000, 0, 0, 0);
    runTxn(2, 8'h0C, 9'h000, 0, 0, 0);      // prot=11
    runTxn(0, 8'h00, 9'h000, 0, 0, 0);
    runTxn(3, 8'h00, 9'h000, 1, 0, 0);      // R6 full array reject
    runTxn(2, 8'hF3, 9'h000, 0, 0, 0);      // prot=00
    runTxn(0, 8'h00, 9'h000, 0, 0, 0);
    runTxn(1, 8'h00, 9'h000, 0, 0, 0);      // R3
    runTxn(3, 8'h00, 9'h040, 2, 0, 0);      // R5 after disable

    for (int t = 0; t < 160; t++) begin
      int r = $urandom % 10;
      int w = $urandom % 8;
      int kind = (r < 3) ? 0 : (r == 3) ? 1 : (r < 6) ? 2 : 3;
      int wpMode = (w == 6) ? 1 : (w == 7) ? 2 : 0;
      runTxn(kind, 8'($urandom), 9'($urandom), int'($urandom % 17), wpMode, 0);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule